// File: doc/BRIEF.md
# Channel trigger and timestamp unit

This block decides, for a single digitizer channel, when an event has occurred, and it tags that event with the value of a free-running time counter. Each channel has its own copy of the block, and no copy depends on any other. A stream of signed samples, one per clock, feeds a digital leading-edge discriminator. The discriminator's decision always appears on a front-panel pulse output.

A two-bit mode input selects the trigger source. In self mode the discriminator triggers the channel. In external mode a rising edge on an external trigger input triggers it. In gated mode a discriminator fire opens a window of programmable length, and the event is accepted only if a rising edge on the validation input arrives inside that window. An accepted event produces a one-cycle strobe. The 48-bit time captured with the event is the time of the discriminator fire, or of the external edge in external mode; it is never the time of the validation edge.

All inputs are assumed synchronous to `clk`. The sample clock is `clk`, and one sample arrives per clock.

Top module: `chan_trig_unit`

## Requirements
- R1: While `rst_n` is low, `disc_out`, `trig_out` and `trig_ts` are 0, and the time counter is held at 0.
- R2: `disc_out` is high for the one cycle after a clock edge at which `sample_in >= threshold` and the sample at the previous edge was `< threshold`. Both comparisons treat the values as signed two's complement. The first edge after reset has no previous sample and cannot fire.
- R3: While samples stay at or above the threshold, the discriminator does not fire again. It can fire again only after a sample below the threshold.
- R4: Mode `00` (self): each discriminator fire raises `trig_out` for one cycle in the same cycle as `disc_out`.
- R5: Mode `01` (external): each rising edge of `ext_trig_in` raises `trig_out` for one cycle after that edge. A long high level gives exactly one strobe. Discriminator fires do not trigger, but `disc_out` still pulses.
- R6: Mode `10` (gated): a discriminator fire at edge F opens a window, provided `win_len` is not 0. A rising edge of `ext_valid_in` at any edge from F+1 to F+`win_len` gives one `trig_out` strobe. In that case `trig_ts` is the counter value at F.
- R7: Mode `10`: no strobe results in any of these cases: the window closes without a validation edge; the validation edge falls on edge F itself; the validation input was already high and only stays high; `win_len` is 0.
- R8: Mode `10`: while a window is open, including the edge at which it closes, further discriminator fires are ignored, and the original fire time is kept.
- R9: Mode `11` gives no strobe. Any mode other than `10` drops an open window, so a later validation edge does not trigger.
- R10: The time counter reads N at the Nth clock edge after reset release, counting from 0, and advances by one per clock. `trig_ts` takes the counter value of the qualifying edge and changes only together with a `trig_out` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_in | input | SAMPLE_W | Signed sample, one per clock |
| threshold | input | SAMPLE_W | Signed discriminator level |
| mode | input | 2 | 00 self, 01 external, 10 gated, 11 off |
| win_len | input | WIN_W | Gated-mode window length in clocks |
| ext_trig_in | input | 1 | External trigger level |
| ext_valid_in | input | 1 | External validation level |
| disc_out | output | 1 | Discriminator pulse for the front panel |
| trig_out | output | 1 | One-cycle trigger strobe |
| trig_ts | output | TS_W | Time captured for the last trigger |

## Verification
The hardest situations to reach from the ports are in gated mode: a validation edge that lands exactly on the last cycle of the window, or one cycle after it; a second fire while a window is open; and a validation level that rose together with the fire. The stimulus reaches them by writing one-clock sample and pulse sequences, with each edge placed at a chosen offset from the fire. A behavioural model checks every cycle, including the captured time. For each sub-sequence, the bench also counts strobes and compares the count against a value worked out by hand.

// File: rtl/chan_trig_pkg.sv
// Shared types for the channel trigger unit.
package chan_trig_pkg;

    // Trigger source selection; the encoding is visible on the mode port.
    typedef enum logic [1:0] {
        MODE_SELF = 2'b00,
        MODE_EXT  = 2'b01,
        MODE_GATE = 2'b10,
        MODE_OFF  = 2'b11
    } trig_mode_e;

    // Number of external pulse inputs that are edge detected.
    localparam int unsigned NUM_EXT = 2;
    localparam int unsigned EXT_TRIG_IDX  = 0;
    localparam int unsigned EXT_VALID_IDX = 1;

endpackage

// File: rtl/trig_disc.sv
// Leading-edge discriminator.
// Fires when the current sample is at or above the threshold while the
// previous sample was below it (signed compare). The fire flag is
// combinational and is used at the same edge; disc_out is its registered copy.
// Assumes one sample per clock, synchronous to clk.
module trig_disc #(
    parameter int unsigned SAMPLE_W = 14
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [SAMPLE_W-1:0] sample_in,
    input  logic signed [SAMPLE_W-1:0] threshold,
    output logic                       fire,
    output logic                       disc_out
);

    logic signed [SAMPLE_W-1:0] prev_q;
    logic                       prev_ok_q;
    logic                       disc_q;

    // Rising crossing: previous below, current at or above.
    always_comb begin
        fire = prev_ok_q && (prev_q < threshold) && (sample_in >= threshold);
    end

    // Keep the previous sample and the registered discriminator pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= '0;
            prev_ok_q <= 1'b0;
            disc_q    <= 1'b0;
        end else begin
            prev_q    <= sample_in;
            prev_ok_q <= 1'b1;
            disc_q    <= fire;
        end
    end

    assign disc_out = disc_q;

endmodule

// File: rtl/trig_edge.sv
// Rising-edge detector for a group of synchronous level inputs.
// rise[i] is high in the cycle where lvl[i] is high and was low at the
// previous edge. Assumes inputs are already synchronous to clk.
module trig_edge #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);

    logic [N-1:0] lvl_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Remember the level of this input from the previous edge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl_q[i] <= 1'b0;
            end else begin
                lvl_q[i] <= lvl[i];
            end
        end

        // Edge is present when the level is high now and was low before.
        always_comb begin
            rise[i] = lvl[i] & ~lvl_q[i];
        end
    end

endmodule

// File: rtl/trig_tstamp.sv
// Free-running time counter: holds 0 in reset, then advances by one on
// every clock and wraps at 2**TS_W.
module trig_tstamp #(
    parameter int unsigned TS_W = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] ts_now
);

    logic [TS_W-1:0] cnt_q;

    // Advance the counter once per sample clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + TS_W'(1);
        end
    end

    assign ts_now = cnt_q;

endmodule

// File: rtl/trig_ctrl.sv
// Trigger mode control and gated-mode window.
// Picks the trigger source from the mode, runs the validation window in
// gated mode and captures the time of the qualifying edge. A fire opens a
// window of win_len edges. A validation edge at any of those edges is
// accepted. Fires during an open window are ignored. Any mode other than
// gated drops an open window. Assumes all inputs are sampled at the same edge.
module trig_ctrl
    import chan_trig_pkg::*;
#(
    parameter int unsigned TS_W  = 48,
    parameter int unsigned WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [WIN_W-1:0] win_len,
    input  logic             fire,
    input  logic             ext_rise,
    input  logic             val_rise,
    input  logic [TS_W-1:0]  ts_now,
    output logic             trig_out,
    output logic [TS_W-1:0]  trig_ts
);

    trig_mode_e       mode_e;
    logic             trig_q;
    logic [TS_W-1:0]  trig_ts_q;
    logic             pend_q;
    logic [WIN_W-1:0] win_cnt_q;
    logic [TS_W-1:0]  pend_ts_q;

    // Decode the mode port into the shared enum.
    always_comb begin
        mode_e = trig_mode_e'(mode);
    end

    // Strobe generation, window tracking and time capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q    <= 1'b0;
            trig_ts_q <= '0;
            pend_q    <= 1'b0;
            win_cnt_q <= '0;
            pend_ts_q <= '0;
        end else begin
            trig_q <= 1'b0;
            unique case (mode_e)
                MODE_SELF: begin
                    pend_q <= 1'b0;
                    if (fire) begin
                        trig_q    <= 1'b1;
                        trig_ts_q <= ts_now;
                    end
                end
                MODE_EXT: begin
                    pend_q <= 1'b0;
                    if (ext_rise) begin
                        trig_q    <= 1'b1;
                        trig_ts_q <= ts_now;
                    end
                end
                MODE_GATE: begin
                    if (pend_q) begin
                        if (val_rise) begin
                            trig_q    <= 1'b1;
                            trig_ts_q <= pend_ts_q;
                            pend_q    <= 1'b0;
                        end else if (win_cnt_q == WIN_W'(1)) begin
                            pend_q <= 1'b0;
                        end else begin
                            win_cnt_q <= win_cnt_q - WIN_W'(1);
                        end
                    end else if (fire && (win_len != '0)) begin
                        pend_q    <= 1'b1;
                        win_cnt_q <= win_len;
                        pend_ts_q <= ts_now;
                    end
                end
                default: begin
                    pend_q <= 1'b0;
                end
            endcase
        end
    end

    assign trig_out = trig_q;
    assign trig_ts  = trig_ts_q;

endmodule

// File: rtl/chan_trig_unit.sv
// Per-channel trigger and timestamp unit (top).
// Connects the discriminator, the external edge detectors, the time counter
// and the mode control. All inputs are synchronous to clk; reset is
// synchronous and active low.
module chan_trig_unit
    import chan_trig_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 14,
    parameter int unsigned TS_W     = 48,
    parameter int unsigned WIN_W    = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [SAMPLE_W-1:0] sample_in,
    input  logic signed [SAMPLE_W-1:0] threshold,
    input  logic [1:0]                 mode,
    input  logic [WIN_W-1:0]           win_len,
    input  logic                       ext_trig_in,
    input  logic                       ext_valid_in,
    output logic                       disc_out,
    output logic                       trig_out,
    output logic [TS_W-1:0]            trig_ts
);

    logic               fire;
    logic [NUM_EXT-1:0] ext_lvl;
    logic [NUM_EXT-1:0] ext_rise;
    logic [TS_W-1:0]    ts_now;

    // Gather the external levels for edge detection.
    always_comb begin
        ext_lvl                = '0;
        ext_lvl[EXT_TRIG_IDX]  = ext_trig_in;
        ext_lvl[EXT_VALID_IDX] = ext_valid_in;
    end

    trig_disc #(.SAMPLE_W(SAMPLE_W)) u_disc (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_in (sample_in),
        .threshold (threshold),
        .fire      (fire),
        .disc_out  (disc_out)
    );

    trig_edge #(.N(NUM_EXT)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (ext_lvl),
        .rise  (ext_rise)
    );

    trig_tstamp #(.TS_W(TS_W)) u_ts (
        .clk    (clk),
        .rst_n  (rst_n),
        .ts_now (ts_now)
    );

    trig_ctrl #(.TS_W(TS_W), .WIN_W(WIN_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .win_len  (win_len),
        .fire     (fire),
        .ext_rise (ext_rise[EXT_TRIG_IDX]),
        .val_rise (ext_rise[EXT_VALID_IDX]),
        .ts_now   (ts_now),
        .trig_out (trig_out),
        .trig_ts  (trig_ts)
    );

endmodule

// File: rtl/chan_trig_chk.sv
// Property checker for chan_trig_unit, attached by bind.
// Observes the ports and the internal time counter.
module chan_trig_chk #(
    parameter int unsigned TS_W = 48
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      mode,
    input logic            ext_trig_in,
    input logic            ext_valid_in,
    input logic            disc_out,
    input logic            trig_out,
    input logic [TS_W-1:0] trig_ts,
    input logic [TS_W-1:0] ts_now
);

    AST_DISC_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        disc_out |=> !disc_out); // R3

    AST_SELF_WITH_DISC: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b00 && trig_out) |-> disc_out); // R4

    AST_EXT_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b01 && trig_out) |-> ($past(ext_trig_in) && !$past(ext_trig_in, 2))); // R5

    AST_GATE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b10 && trig_out) |-> ($past(ext_valid_in) && !$past(ext_valid_in, 2))); // R6

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b11) |-> !trig_out); // R9

    AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ts_now == $past(ts_now) + TS_W'(1))); // R10

    AST_TS_ONLY_ON_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_ts != $past(trig_ts)) |-> trig_out); // R10

endmodule

bind chan_trig_unit chan_trig_chk #(.TS_W(TS_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode),
    .ext_trig_in  (ext_trig_in),
    .ext_valid_in (ext_valid_in),
    .disc_out     (disc_out),
    .trig_out     (trig_out),
    .trig_ts      (trig_ts),
    .ts_now       (ts_now)
);

// File: tb/chan_trig_unit_tb.sv
// Bench for chan_trig_unit: behavioural model compared every clock, plus
// hand-computed strobe counts per stimulus sequence.
module chan_trig_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SW = 14;
    localparam int TW = 48;
    localparam int WW = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic signed [SW-1:0] sample_in = '0;
    logic signed [SW-1:0] threshold = 14'(100);
    logic [1:0]           mode = 2'b00;
    logic [WW-1:0]        win_len = 16'(4);
    logic                 ext_trig_in = 1'b0;
    logic                 ext_valid_in = 1'b0;
    logic                 disc_out;
    logic                 trig_out;
    logic [TW-1:0]        trig_ts;

    int checks = 0;
    int errors = 0;
    int n_trig = 0;
    int n_disc = 0;
    int cycles = 0;
    bit done = 1'b0;

    chan_trig_unit #(.SAMPLE_W(SW), .TS_W(TW), .WIN_W(WW)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_in    (sample_in),
        .threshold    (threshold),
        .mode         (mode),
        .win_len      (win_len),
        .ext_trig_in  (ext_trig_in),
        .ext_valid_in (ext_valid_in),
        .disc_out     (disc_out),
        .trig_out     (trig_out),
        .trig_ts      (trig_ts)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state.
    int     m_prev;
    bit     m_hp, m_ep, m_vp, m_pend;
    int     m_cnt;
    longint m_ts, m_pts;
    bit     e_disc, e_trig;
    longint e_ts;

    always @(posedge clk) begin
        int  s, th;
        bit  fire, er, vr;
        if (!rst_n) begin
            m_prev = 0; m_hp = 0; m_ep = 0; m_vp = 0; m_pend = 0; m_cnt = 0;
            m_ts = 0; m_pts = 0; e_disc = 0; e_trig = 0; e_ts = 0;
        end else begin
            s  = int'(sample_in);
            th = int'(threshold);
            fire = m_hp && (m_prev < th) && (s >= th);
            er = ext_trig_in && !m_ep;
            vr = ext_valid_in && !m_vp;
            e_disc = fire;
            e_trig = 0;
            case (mode)
                2'b00: begin m_pend = 0; if (fire) begin e_trig = 1; e_ts = m_ts; end end
                2'b01: begin m_pend = 0; if (er) begin e_trig = 1; e_ts = m_ts; end end
                2'b10: begin
                    if (m_pend) begin
                        if (vr) begin e_trig = 1; e_ts = m_pts; m_pend = 0; end
                        else if (m_cnt == 1) m_pend = 0;
                        else m_cnt = m_cnt - 1;
                    end else if (fire && win_len != 0) begin
                        m_pend = 1; m_cnt = int'(win_len); m_pts = m_ts;
                    end
                end
                default: m_pend = 0;
            endcase
            m_prev = s; m_hp = 1; m_ep = ext_trig_in; m_vp = ext_valid_in;
            m_ts = m_ts + 1;
        end
    end

    // Count strobes as seen just before each edge.
    always @(posedge clk) begin
        if (trig_out) n_trig <= n_trig + 1;
        if (disc_out) n_disc <= n_disc + 1;
    end

    // Compare against the model every cycle, away from the active edge.
    always @(negedge clk) begin
        string tg;
        if (!done) begin
            checks++;
            if (!rst_n) tg = "R1";
            else case (mode)
                2'b00: tg = "R4"; 2'b01: tg = "R5"; 2'b10: tg = "R6"; default: tg = "R9";
            endcase
            if (disc_out !== e_disc) begin
                errors++;
                $display("FAIL R2 disc_out act=%0b exp=%0b t=%0t", disc_out, e_disc, $time);
            end
            if (trig_out !== e_trig) begin
                errors++;
                $display("FAIL %s trig_out act=%0b exp=%0b t=%0t", tg, trig_out, e_trig, $time);
            end
            if (trig_ts !== 48'(e_ts)) begin
                errors++;
                $display("FAIL R10 trig_ts act=%0d exp=%0d t=%0t", trig_ts, e_ts, $time);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog act=%0d exp=<20000 cycles", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // One sample per clock; values apply to the following edge.
    task automatic step(input int s, input bit e, input bit v);
        @(negedge clk);
        sample_in    = 14'(s);
        ext_trig_in  = e;
        ext_valid_in = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0);
    endtask

    int bt, bd;

    initial begin
        repeat (4) @(negedge clk);
        check(disc_out == 0 && trig_out == 0 && trig_ts == 0, "R1 reset outputs", int'(trig_out), 0);
        rst_n = 1'b1;   // edge 0 follows

        // Self mode, threshold 100: crossings at 150 and 120.
        bt = n_trig; bd = n_disc;
        step(0, 0, 0); step(50, 0, 0); step(150, 0, 0); step(200, 0, 0);
        check(trig_out == 1, "R4 strobe with fire", int'(trig_out), 1);
        check(trig_ts == 48'(3), "R10 captured time", int'(trig_ts), 3);
        step(180, 0, 0); step(90, 0, 0); step(120, 0, 0); step(30, 0, 0); idle(3);
        check(n_disc - bd == 2, "R3 refire only after dip", n_disc - bd, 2);
        check(n_trig - bt == 2, "R4 self strobes", n_trig - bt, 2);

        // Negative threshold: signed compare.
        threshold = 14'(-50);
        bd = n_disc;
        step(-100, 0, 0); step(-60, 0, 0); step(-40, 0, 0); step(-30, 0, 0);
        step(-200, 0, 0); step(10, 0, 0); idle(3);
        check(n_disc - bd == 2, "R2 signed crossings", n_disc - bd, 2);
        threshold = 14'(100);

        // External mode.
        mode = 2'b01; idle(2);
        bt = n_trig; bd = n_disc;
        step(0, 1, 0); step(200, 1, 0); step(200, 1, 0); step(200, 1, 0);
        step(0, 1, 0); step(0, 0, 0); step(0, 1, 0); step(0, 0, 0); idle(3);
        check(n_trig - bt == 2, "R5 one strobe per ext edge", n_trig - bt, 2);
        check(n_disc - bd == 1, "R5 disc still pulses", n_disc - bd, 1);

        // Gated mode, window 4.
        mode = 2'b10; win_len = 16'(4); idle(2);
        bt = n_trig;
        step(200, 0, 0); step(0, 0, 0); step(0, 0, 1); step(0, 0, 0); idle(3);
        check(n_trig - bt == 1, "R6 validation inside window", n_trig - bt, 1);
        bt = n_trig;
        step(200, 0, 0); step(0, 0, 0); step(0, 0, 0); step(0, 0, 0); step(0, 0, 1);
        step(0, 0, 0); idle(3);
        check(n_trig - bt == 1, "R6 validation on last window edge", n_trig - bt, 1);
        bt = n_trig;
        step(200, 0, 0); idle(4); step(0, 0, 1); step(0, 0, 0); idle(3);
        check(n_trig - bt == 0, "R7 validation one edge late", n_trig - bt, 0);
        bt = n_trig;
        step(200, 0, 1); step(0, 0, 1); step(0, 0, 1); step(0, 0, 1); idle(4);
        check(n_trig - bt == 0, "R7 validation with fire then held", n_trig - bt, 0);
        bt = n_trig;
        step(200, 0, 0); step(0, 0, 0); step(200, 0, 0); step(0, 0, 0); step(0, 0, 1);
        step(0, 0, 0); idle(3);
        check(n_trig - bt == 1, "R8 second fire ignored", n_trig - bt, 1);
        win_len = 16'(0); idle(2);
        bt = n_trig;
        step(200, 0, 0); step(0, 0, 1); step(0, 0, 0); idle(3);
        check(n_trig - bt == 0, "R7 zero window", n_trig - bt, 0);

        // Off mode and window drop on mode change.
        mode = 2'b11; idle(2);
        bt = n_trig; bd = n_disc;
        step(200, 1, 1); step(0, 0, 0); step(200, 0, 0); step(0, 0, 0); idle(3);
        check(n_trig - bt == 0, "R9 off mode silent", n_trig - bt, 0);
        check(n_disc - bd == 2, "R9 disc in off mode", n_disc - bd, 2);
        mode = 2'b10; win_len = 16'(8); idle(2);
        bt = n_trig;
        step(200, 0, 0); step(0, 0, 0); mode = 2'b00;
        step(0, 0, 0); mode = 2'b10;
        step(0, 0, 1); step(0, 0, 0); idle(3);
        check(n_trig - bt == 0, "R9 window dropped on mode change", n_trig - bt, 0);

        idle(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule